// File: doc/BRIEF.md
# Leading-One Binary Logarithm Approximator

This block takes an unsigned integer operand and produces an approximate base-2 logarithm in fixed point. The integer part of the result is the bit index of the operand's most significant set bit. The fractional part is made from the operand bits that lie below that bit. They are moved up so that the bit just under the leading one becomes the first bit after the binary point. The value the block represents is therefore k + x, where k is the leading-one index and 0 ≤ x < 1. The true logarithm would be k + log2(1 + x). When the operand is an exact power of two, the approximation is exact.

The leading-one search and the fraction alignment both complete in one combinational pass. The search is a priority encoder and the alignment is a logarithmic shifter, so no iterative shift-and-count loop is needed. A zero operand has no logarithm, and the block reports it with a separate flag. A build-time choice places an output register after the logic for pipelined use, or leaves the result purely combinational. The intended users are log-domain arithmetic datapaths, which add logarithms in place of multiplying operands.

Top module: `lzlog_conv`

## Requirements
- R1: For a non-zero operand, `char_o` equals the bit index of the operand's most significant set bit (0 for operand 1, OP_W-1 when the top bit is set).
- R2: For a non-zero operand with leading one at index k, `frac_o` bit OP_W-2-j equals operand bit k-1-j for j = 0..k-1. The remaining OP_W-1-k low bits of `frac_o` are zero.
- R3: With OP_W = 10, operand 25 (binary 11001) gives `char_o` = 4 and `frac_o` = 9'b100100000, i.e. 100.1001 in binary = 4.5625.
- R4: For an operand that is an exact power of two, `frac_o` is all zeros and `char_o` equals the exponent.
- R5: An operand of zero drives `zero_o` high with `char_o` and `frac_o` both zero. Every non-zero operand drives `zero_o` low.
- R6: With OUT_MODE = OUT_REG, the outputs reflect the operand sampled at the previous rising clock edge and keep their value until the next edge. With OUT_MODE = OUT_COMB, the outputs follow the operand within the same cycle.
- R7: With OUT_MODE = OUT_REG, a rising edge with `rst_n` low clears `char_o`, `frac_o` and `zero_o` to zero, whatever the operand is.
- R8: The all-ones operand gives `char_o` = OP_W-1 and an all-ones `frac_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| op_i | input | OP_W | Unsigned operand |
| char_o | output | $clog2(OP_W) | Integer part of the logarithm (leading-one index) |
| frac_o | output | OP_W-1 | Fractional part, left-justified below the binary point |
| zero_o | output | 1 | High when the operand is zero |

## Verification
The hardest case is the alignment of the fraction when the leading one sits low. In that case most of `frac_o` must come out as zero fill, and only a few operand bits reach the top of the field after the largest shift through every shifter stage. Small operands such as 1, 2, 3 and 5 reach that case directly. The bench sweeps every 10-bit operand in order through both a registered and a combinational instance, so every shift amount and every pattern below the leading one is exercised. Expected values come from arithmetic on the operand: the fraction is computed as (v - 2^k) * 2^(OP_W-1-k).

// File: rtl/lzlog_pkg.sv
// Package: shared definitions for the leading-one logarithm approximator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package lzlog_pkg;

    // Selects whether the result leaves through a register or straight from logic.
    typedef enum logic {
        OUT_COMB = 1'b0,
        OUT_REG  = 1'b1
    } lzlog_out_mode_e;

endpackage

// File: rtl/lzlog_lead_one.sv
// Module: lzlog_lead_one
// Finds the index of the most significant set bit of the operand in one
// combinational pass, and reports whether any bit is set at all.
// Assumes OP_W >= 2. The index is zero when the operand is zero.
module lzlog_lead_one #(
    parameter int OP_W  = 16,
    parameter int IDX_W = $clog2(OP_W)
) (
    input  logic [OP_W-1:0]  op_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);

    // Priority encoder: the highest set bit overwrites any lower one.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < OP_W; i++) begin
            if (op_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

    // Non-zero detection.
    assign any_o = |op_i;

endmodule

// File: rtl/lzlog_align.sv
// Module: lzlog_align
// Left-justifies the bits below the leading one into the fraction field.
// It shifts the operand's low OP_W-1 bits left by (OP_W-1-idx) through a
// logarithmic shifter, one stage per bit of the shift amount. Bits pushed
// past the top fall off, and the leading one is among them.
// Assumes idx_i <= OP_W-1.
module lzlog_align #(
    parameter int OP_W  = 16,
    parameter int IDX_W = $clog2(OP_W)
) (
    input  logic [OP_W-2:0]  low_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [OP_W-2:0]  frac_o
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(OP_W - 1);

    logic [IDX_W-1:0] shamt;
    logic [OP_W-2:0]  stage [0:IDX_W];

    // Distance from the leading one to the top bit position.
    assign shamt    = TOP_IDX - idx_i;
    assign stage[0] = low_i;

    // One conditional power-of-two shift for each bit of the shift amount.
    for (genvar s = 0; s < IDX_W; s++) begin : g_shift
        assign stage[s+1] = shamt[s] ? (stage[s] << (1 << s)) : stage[s];
    end

    assign frac_o = stage[IDX_W];

endmodule

// File: rtl/lzlog_out_stage.sv
// Module: lzlog_out_stage
// Either registers the result, with a synchronous active-low reset that
// clears it, or passes it straight through, as OUT_MODE selects.
// In OUT_COMB mode clk and rst_n have no effect.
module lzlog_out_stage
    import lzlog_pkg::*;
#(
    parameter int              OP_W     = 16,
    parameter int              IDX_W    = $clog2(OP_W),
    parameter lzlog_out_mode_e OUT_MODE = OUT_REG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] char_i,
    input  logic [OP_W-2:0]  frac_i,
    input  logic             zero_i,
    output logic [IDX_W-1:0] char_o,
    output logic [OP_W-2:0]  frac_o,
    output logic             zero_o
);

    if (OUT_MODE == OUT_REG) begin : g_reg
        // Pipeline register for the whole result.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                char_o <= '0;
                frac_o <= '0;
                zero_o <= 1'b0;
            end else begin
                char_o <= char_i;
                frac_o <= frac_i;
                zero_o <= zero_i;
            end
        end
    end else begin : g_comb
        assign char_o = char_i;
        assign frac_o = frac_i;
        assign zero_o = zero_i;
    end

endmodule

// File: rtl/lzlog_conv.sv
// Module: lzlog_conv (top)
// Approximates log2 of an unsigned operand as k + x. k is the leading-one
// index and x is the remaining bits left-justified below the binary point.
// A zero operand raises zero_o, and the integer and fraction parts are then
// zero. Assumes OP_W >= 2.
module lzlog_conv
    import lzlog_pkg::*;
#(
    parameter int              OP_W     = 16,
    parameter lzlog_out_mode_e OUT_MODE = OUT_REG,
    localparam int             IDX_W    = $clog2(OP_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  op_i,
    output logic [IDX_W-1:0] char_o,
    output logic [OP_W-2:0]  frac_o,
    output logic             zero_o
);

    logic [IDX_W-1:0] lead_idx;
    logic             lead_any;
    logic [OP_W-2:0]  frac_raw;
    logic             zero_raw;

    lzlog_lead_one #(.OP_W(OP_W), .IDX_W(IDX_W)) lead_i (
        .op_i  (op_i),
        .idx_o (lead_idx),
        .any_o (lead_any)
    );

    lzlog_align #(.OP_W(OP_W), .IDX_W(IDX_W)) align_i (
        .low_i  (op_i[OP_W-2:0]),
        .idx_i  (lead_idx),
        .frac_o (frac_raw)
    );

    // A zero operand is flagged. The index and fraction are already zero then.
    assign zero_raw = ~lead_any;

    lzlog_out_stage #(.OP_W(OP_W), .IDX_W(IDX_W), .OUT_MODE(OUT_MODE)) out_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .char_i (lead_idx),
        .frac_i (frac_raw),
        .zero_i (zero_raw),
        .char_o (char_o),
        .frac_o (frac_o),
        .zero_o (zero_o)
    );

endmodule

// File: rtl/lzlog_conv_chk.sv
// Module: lzlog_conv_chk
// Checker bound to lzlog_conv. It keeps its own copy of the operand, aligned
// to the output latency, and relates the outputs to that copy.
module lzlog_conv_chk
    import lzlog_pkg::*;
#(
    parameter int              OP_W     = 16,
    parameter lzlog_out_mode_e OUT_MODE = OUT_REG,
    localparam int             IDX_W    = $clog2(OP_W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OP_W-1:0]  op_i,
    input logic [IDX_W-1:0] char_o,
    input logic [OP_W-2:0]  frac_o,
    input logic             zero_o
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(OP_W - 1);

    logic            primed_q;
    logic [OP_W-1:0] op_q;
    logic [OP_W-1:0] ref_op;
    logic            live;

    // Operand copy delayed by one cycle, and a flag set once it is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed_q <= 1'b0;
            op_q     <= '0;
        end else begin
            primed_q <= 1'b1;
            op_q     <= op_i;
        end
    end

    assign ref_op = (OUT_MODE == OUT_REG) ? op_q : op_i;
    assign live   = (OUT_MODE == OUT_REG) ? primed_q : 1'b1;

    assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (zero_o == (ref_op == '0)));

    assert_zero_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o |-> (char_o == '0 && frac_o == '0));

    assert_char_msb_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !zero_o) |-> ((ref_op >> char_o) == OP_W'(1)));

    assert_frac_rebuild_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !zero_o) |-> (({1'b1, frac_o} >> (TOP_IDX - char_o)) == ref_op));

    assert_pow2_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $countones(ref_op) == 1) |-> (frac_o == '0));

    if (OUT_MODE == OUT_REG) begin : g_reg_chk
        assert_reset_clear_R7: assert property (@(posedge clk)
            !rst_n |=> (char_o == '0 && frac_o == '0 && !zero_o));
    end

endmodule

bind lzlog_conv lzlog_conv_chk #(.OP_W(OP_W), .OUT_MODE(OUT_MODE)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_i   (op_i),
    .char_o (char_o),
    .frac_o (frac_o),
    .zero_o (zero_o)
);

// File: tb/lzlog_conv_tb_top.sv
`timescale 1ns/1ps
// Bench: every 10-bit operand is applied to a registered instance and to a
// combinational instance, and both are checked against arithmetic models.
module lzlog_conv_tb_top;
    import lzlog_pkg::*;

    localparam int OP_W  = 10;
    localparam int IDX_W = $clog2(OP_W);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [OP_W-1:0]  op = '0;
    logic [IDX_W-1:0] char_r, char_c;
    logic [OP_W-2:0]  frac_r, frac_c;
    logic             zero_r, zero_c;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    lzlog_conv #(.OP_W(OP_W), .OUT_MODE(OUT_REG)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op),
        .char_o(char_r), .frac_o(frac_r), .zero_o(zero_r));

    lzlog_conv #(.OP_W(OP_W), .OUT_MODE(OUT_COMB)) dut_comb_i (
        .clk(clk), .rst_n(rst_n), .op_i(op),
        .char_o(char_c), .frac_o(frac_c), .zero_o(zero_c));

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Leading-one index computed by division.
    function automatic int exp_char(input int v);
        int k = 0;
        int t = v;
        while (t > 1) begin
            t = t / 2;
            k++;
        end
        return k;
    endfunction

    // Fraction computed as (v - 2^k) * 2^(OP_W-1-k).
    function automatic int exp_frac(input int v);
        int k;
        if (v == 0) return 0;
        k = exp_char(v);
        return (v - (1 << k)) * (1 << (OP_W - 1 - k));
    endfunction

    task automatic check_all(input string tag, input int v,
                             input int c, input int f, input int z);
        check({tag, " R1 char"}, c, (v == 0) ? 0 : exp_char(v));
        check({tag, " R2 frac"}, f, exp_frac(v));
        check({tag, " R5 zero"}, z, (v == 0) ? 1 : 0);
    endtask

    initial begin
        // R7: reset clears the registered outputs even with a full operand.
        op = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 char in reset", int'(char_r), 0);
        check("R7 frac in reset", int'(frac_r), 0);
        check("R7 zero in reset", int'(zero_r), 0);
        rst_n = 1'b1;

        // Ascending sweep: the registered result lags the operand by one cycle (R6).
        for (int v = 0; v <= (1 << OP_W); v++) begin
            if (v > 0) begin
                check_all("reg R6", v - 1, int'(char_r), int'(frac_r), int'(zero_r));
                if (v - 1 == 25) begin
                    check("R3 char of 25", int'(char_r), 4);
                    check("R3 frac of 25", int'(frac_r), 9'b100100000);
                end
                if (v - 1 == (1 << OP_W) - 1) begin
                    check("R8 char all ones", int'(char_r), OP_W - 1);
                    check("R8 frac all ones", int'(frac_r), (1 << (OP_W - 1)) - 1);
                end
            end
            if (v < (1 << OP_W)) begin
                op = OP_W'(v);
                #1;
                check_all("comb R6", v, int'(char_c), int'(frac_c), int'(zero_c));
                if ((v & (v - 1)) == 0 && v != 0) begin
                    check("R4 pow2 frac", int'(frac_c), 0);
                    check("R4 pow2 char", int'(char_c), exp_char(v));
                end
            end
            @(negedge clk);
        end

        // R6: the registered output holds its value while no edge has occurred.
        op = 10'd25;
        @(negedge clk);
        op = 10'd0;
        #1;
        check("R6 hold char", int'(char_r), 4);
        check("R6 hold frac", int'(frac_r), 9'b100100000);
        @(negedge clk);
        check("R5 zero after 0", int'(zero_r), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: counts as a failure and still prints the summary.
    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule